// File: doc/BRIEF.md
# Timer Channel Start-Interrupt Control

This block is one channel of a multi-mode timer. It holds a 4-bit operating-mode field, a start-interrupt enable bit and a reload value. It also keeps a channel-run flag. The block decides whether a one-cycle interrupt pulse goes out when the counter begins counting. Three things can begin a count: starting the channel from the stopped state, a forced restart from software, or a rising edge on the external trigger pin. Whether that pulse appears depends on the mode together with the enable bit. Some modes follow the bit, one mode never fires and one mode always fires.

Interval mode is fully built. The counter loads the reload value at every start event and then counts down by one per clock. When it is at zero it reloads and raises the interrupt. The other modes implement only their start-interrupt policy and a simple up-counting stub. The mode field and the enable bit are locked while the channel runs.

There is no data stream here. Every pin is a plain control or status signal, so the block has no valid/ready handshake and no back-pressure.

Top module: `tmr_chan_start_irq`

## Requirements
- R1: With mode codes 0 (interval), 1 (capture) or 2 (count-capture), a start event gives an interrupt pulse only when the start-interrupt bit is 1.
- R2: With mode codes 3 (capture+one-count), 4 (capture+gate-count), 5 (event count) or 6 (up/down), a start event gives no pulse when the bit is 0 and gives a pulse when the bit is 1.
- R3: With mode code 7 (one-count), a start event never gives a pulse, whatever the value of the bit.
- R4: With mode code 8 (pulse one-count), a start event always gives a pulse, whatever the value of the bit.
- R5: A configuration write (mode and bit) while `run_o` is 1 is ignored, and `mode_o`/`sirq_o` keep their values. While stopped, the write takes effect on the next clock.
- R6: Asserting `run_set_i` while stopped sets `run_o` on the next clock and loads the counter. The start interrupt, when allowed, is high during that same cycle. `run_clr_i` stops the channel and wins over any event in the same cycle.
- R7: `restart_i` while running is a start event: it reloads the counter and is subject to the same interrupt policy.
- R8: A rising edge on the asynchronous `trig_i` passes through a 2-flop synchroniser. It acts as a start event while running, and its pulse appears three clocks after the edge is sampled.
- R9: In interval mode a running counter decrements each clock. At zero it reloads the reload value and raises `irq_o` for that cycle.
- R10: A start event that coincides with an underflow yields one single-cycle `irq_o` pulse, not two.
- R11: Mode codes 9 to 15 count as in interval mode but never produce a start interrupt.
- R12: After reset: `run_o`=0, mode=0, bit=0, counter=0, `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write mode field and start-interrupt bit |
| cfg_mode_i | input | 4 | Mode code to write |
| cfg_sirq_i | input | 1 | Start-interrupt bit to write |
| data_we_i | input | 1 | Write reload value |
| data_i | input | CNT_W | Reload value |
| run_set_i | input | 1 | Start the channel |
| run_clr_i | input | 1 | Stop the channel |
| restart_i | input | 1 | Forced restart while running |
| trig_i | input | 1 | Asynchronous external trigger |
| run_o | output | 1 | Channel running flag |
| mode_o | output | 4 | Current mode code |
| sirq_o | output | 1 | Current start-interrupt bit |
| cnt_o | output | CNT_W | Counter value |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench builds the block with CNT_W=8 and SYNC_STAGES=2. The short 8-bit counter, with reload values of 0 to 4, brings underflow within a few clocks. That makes restarts landing exactly on a zero count, and reload every cycle at value 0, easy to reach. Two synchroniser stages fix the trigger-to-pulse latency at three clocks, and the bench model checks it cycle by cycle.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [3:0] {
    MD_INTERVAL = 4'd0,
    MD_CAPTURE  = 4'd1,
    MD_CNTCAP   = 4'd2,
    MD_CAP_ONE  = 4'd3,
    MD_CAP_GATE = 4'd4,
    MD_EVENT    = 4'd5,
    MD_UPDOWN   = 4'd6,
    MD_ONECNT   = 4'd7,
    MD_PULSE1   = 4'd8
  } mode_e;

  localparam int unsigned MODE_W = 4;

  // Interval behaviour also covers the unassigned codes 9..15.
  function automatic logic counts_down(input logic [MODE_W-1:0] m);
    return (m == MD_INTERVAL) || (m > MD_PULSE1);
  endfunction
endpackage

// File: rtl/tsc_cfg_regs.sv
module tsc_cfg_regs
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              cfg_we_i,
  input  logic [MODE_W-1:0] cfg_mode_i,
  input  logic              cfg_sirq_i,
  input  logic              data_we_i,
  input  logic [CNT_W-1:0]  data_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              sirq_o,
  output logic [CNT_W-1:0]  data_o
);
  logic [MODE_W-1:0] mode_q;
  logic              sirq_q;
  logic [CNT_W-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      sirq_q <= 1'b0;
    end else if (cfg_we_i && !lock_i) begin
      mode_q <= cfg_mode_i;
      sirq_q <= cfg_sirq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (data_we_i) data_q <= data_i;
  end

  assign mode_o = mode_q;
  assign sirq_o = sirq_q;
  assign data_o = data_q;

  // R5: configuration is frozen while counting
  a_r5_cfg_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && cfg_we_i) |=> ($stable(mode_q) && $stable(sirq_q)));
endmodule

// File: rtl/tsc_trig_sync.sv
module tsc_trig_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= trig_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[g] <= 1'b0;
          else         stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stage_q[LAST];
  end

  assign rise_o = stage_q[LAST] && !prev_q;

  // R8: an edge report never lasts two cycles
  a_r8_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tsc_start_policy.sv
module tsc_start_policy
  import tsc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  input  logic              sirq_i,
  output logic              allow_o
);
  always_comb begin
    unique case (mode_i)
      MD_INTERVAL, MD_CAPTURE, MD_CNTCAP,
      MD_CAP_ONE, MD_CAP_GATE, MD_EVENT, MD_UPDOWN: allow_o = sirq_i;
      MD_ONECNT:  allow_o = 1'b0;
      MD_PULSE1:  allow_o = 1'b1;
      default:    allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic             load_i,
  input  logic             down_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             zero;

  assign zero = (cnt_q == '0);
  assign uf_o = run_i && down_i && zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= cnt_q;
    else if (load_i) cnt_q <= reload_i;
    else if (run_i) begin
      if (down_i) cnt_q <= zero ? reload_i : cnt_q - 1'b1;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R9: countdown step
  a_r9_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hold_i && !load_i && down_i && cnt_q != '0)
      |=> cnt_q == CNT_W'($past(cnt_q) - 1'b1));
  // R9: reload at zero
  a_r9_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !hold_i && !load_i && down_i && cnt_q == '0)
      |=> cnt_q == $past(reload_i));
endmodule

// File: rtl/tmr_chan_start_irq.sv
module tmr_chan_start_irq
  import tsc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [3:0]       cfg_mode_i,
  input  logic             cfg_sirq_i,
  input  logic             data_we_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             run_set_i,
  input  logic             run_clr_i,
  input  logic             restart_i,
  input  logic             trig_i,
  output logic             run_o,
  output logic [3:0]       mode_o,
  output logic             sirq_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  logic              run_q, irq_q;
  logic [MODE_W-1:0] mode_q;
  logic              sirq_q, allow, trig_rise, uf;
  logic [CNT_W-1:0]  reload;
  logic              ev_start, ev_restart, ev_trig, ev_any;

  tsc_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni, .lock_i(run_q),
    .cfg_we_i, .cfg_mode_i, .cfg_sirq_i,
    .data_we_i, .data_i,
    .mode_o(mode_q), .sirq_o(sirq_q), .data_o(reload)
  );

  tsc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .trig_i, .rise_o(trig_rise)
  );

  tsc_start_policy u_pol (.mode_i(mode_q), .sirq_i(sirq_q), .allow_o(allow));

  assign ev_start   = run_set_i && !run_clr_i && !run_q;
  assign ev_restart = restart_i && !run_clr_i && run_q;
  assign ev_trig    = trig_rise && !run_clr_i && run_q;
  assign ev_any     = ev_start || ev_restart || ev_trig;

  tsc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(run_q), .hold_i(run_clr_i), .load_i(ev_any),
    .down_i(counts_down(mode_q)), .reload_i(reload),
    .cnt_o, .uf_o(uf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 1'b0;
    else if (run_clr_i) run_q <= 1'b0;
    else if (run_set_i) run_q <= 1'b1;
  end

  // One merged pulse: start permission OR underflow
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (ev_any && allow) || uf;
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
  assign sirq_o = sirq_q;
  assign irq_o  = irq_q;

  // R3: one-count start is silent
  a_r3_onecnt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_any && mode_q == MD_ONECNT) |=> !irq_o);
  // R4: pulse one-count start always fires
  a_r4_pulse1_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_any && mode_q == MD_PULSE1) |=> irq_o);
  // R1: interval start with bit clear stays silent unless underflow
  a_r1_interval_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_any && mode_q == MD_INTERVAL && !sirq_q && !uf) |=> !irq_o);
  // R6: start from stopped raises run flag
  a_r6_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_set_i && !run_clr_i && !run_o) |=> run_o);
  // R11: unused codes never give a start interrupt
  a_r11_unused_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_any && mode_q > MD_PULSE1 && !uf) |=> !irq_o);
endmodule

// File: tb/tmr_chan_start_irq_tb.sv
module tmr_chan_start_irq_tb_top;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_sirq = 0, data_we = 0;
  logic [3:0] cfg_mode = 0;
  logic [CW-1:0] data = 0;
  logic run_set = 0, run_clr = 0, restart = 0, trig = 0;
  logic run_o, sirq_o, irq_o;
  logic [3:0] mode_o;
  logic [CW-1:0] cnt_o;

  int checks = 0, fails = 0;
  string cur_req = "R12";

  // reference state
  int m_run, m_mode, m_sirq, m_data, m_cnt, m_irq, m_s1, m_s2, m_p;

  always #4 clk = ~clk; // 125 MHz

  tmr_chan_start_irq #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_mode_i(cfg_mode),
    .cfg_sirq_i(cfg_sirq), .data_we_i(data_we), .data_i(data),
    .run_set_i(run_set), .run_clr_i(run_clr), .restart_i(restart), .trig_i(trig),
    .run_o(run_o), .mode_o(mode_o), .sirq_o(sirq_o), .cnt_o(cnt_o), .irq_o(irq_o)
  );

  function automatic int policy(int md, int b);
    if (md <= 6) return b;
    if (md == 8) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_mode = 0; m_sirq = 0; m_data = 0; m_cnt = 0; m_irq = 0;
      m_s1 = 0; m_s2 = 0; m_p = 0;
    end else begin
      int ev, dn, uf, ncnt;
      ev = (run_set && !run_clr && !m_run) ||
           (m_run && !run_clr && (restart || (m_s2 && !m_p)));
      dn = (m_mode == 0) || (m_mode > 8);
      uf = m_run && dn && (m_cnt == 0);
      m_irq = ((ev != 0) && policy(m_mode, m_sirq) != 0) || (uf != 0);
      ncnt = m_cnt;
      if (run_clr) ncnt = m_cnt;
      else if (ev) ncnt = m_data;
      else if (m_run) begin
        if (dn) ncnt = (m_cnt == 0) ? m_data : m_cnt - 1;
        else    ncnt = (m_cnt + 1) % 256;
      end
      m_cnt = ncnt;
      if (cfg_we && !m_run) begin m_mode = cfg_mode; m_sirq = cfg_sirq; end
      if (data_we) m_data = data;
      if (run_clr) m_run = 0; else if (run_set) m_run = 1;
      m_p = m_s2; m_s2 = m_s1; m_s1 = trig;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("irq_o", irq_o, m_irq);
    chk("cnt_o", cnt_o, m_cnt);
    chk("run_o", run_o, m_run);
    chk("mode_o", mode_o, m_mode);
    chk("sirq_o", sirq_o, m_sirq);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();
    run_set = 1; @(negedge clk); run_set = 0;
  endtask

  task automatic pulse_clr();
    run_clr = 1; @(negedge clk); run_clr = 0;
  endtask

  task automatic set_cfg(int md, int b);
    cfg_we = 1; cfg_mode = md[3:0]; cfg_sirq = b[0];
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_data(int v);
    data_we = 1; data = v[CW-1:0]; @(negedge clk); data_we = 0;
  endtask

  // start, watch the start cycle, stop
  task automatic try_mode(int md, int b);
    set_cfg(md, b);
    pulse_set();
    idle(6);
    pulse_clr();
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    cur_req = "R12";
    chk("reset run", run_o, 0); chk("reset irq", irq_o, 0);
    chk("reset cnt", cnt_o, 0); chk("reset mode", mode_o, 0);

    set_data(3);
    cur_req = "R1";
    for (int md = 0; md <= 2; md++) for (int b = 0; b <= 1; b++) try_mode(md, b);
    cur_req = "R2";
    for (int md = 3; md <= 6; md++) for (int b = 0; b <= 1; b++) try_mode(md, b);
    cur_req = "R3";
    try_mode(7, 0); try_mode(7, 1);
    cur_req = "R4";
    try_mode(8, 0); try_mode(8, 1);
    cur_req = "R11";
    try_mode(12, 1); try_mode(15, 0);

    cur_req = "R5";
    set_cfg(0, 1);
    pulse_set();
    set_cfg(7, 0);
    idle(1);
    chk("locked mode", mode_o, 0);
    chk("locked sirq", sirq_o, 1);
    pulse_clr();
    set_cfg(5, 0);
    chk("unlocked mode", mode_o, 5);

    cur_req = "R6";
    set_cfg(0, 1);
    run_set = 1; run_clr = 1; @(negedge clk); run_set = 0; run_clr = 0;
    chk("clr wins", run_o, 0);
    pulse_set();
    chk("start irq", irq_o, 1);
    chk("start load", cnt_o, 3);

    cur_req = "R7";
    set_data(4);
    idle(1);
    restart = 1; @(negedge clk); restart = 0;
    chk("restart load", cnt_o, 4);
    chk("restart irq", irq_o, 1);
    idle(3);

    cur_req = "R8";
    trig = 1; idle(4); trig = 0; idle(6);
    pulse_clr();
    set_cfg(1, 0);
    pulse_set();
    trig = 1; idle(4); trig = 0; idle(4);
    pulse_clr();

    cur_req = "R9";
    set_cfg(0, 0);
    set_data(2);
    pulse_set();
    idle(12);
    set_data(0);
    idle(5);
    pulse_clr();

    cur_req = "R10";
    set_cfg(0, 1);
    set_data(3);
    pulse_set();
    while (cnt_o != 0) @(negedge clk);
    restart = 1; @(negedge clk); restart = 0;
    chk("single pulse high", irq_o, 1);
    @(negedge clk);
    chk("single pulse low", irq_o, 0);
    idle(3);
    pulse_clr();
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule